// File: doc/BRIEF.md
# Match Channel Bank

The block holds eight extended timer channels, numbered 4 to 11 at the system level and 0 to 7 inside the block. Each channel keeps a counter, a match value and a control word. Every counter advances on a single-cycle tick enable. The control word picks that enable from five external tick lines, or picks none. A channel compares either its own counter or the counter of the lead channel in its group. When the compared counter steps onto the match value, the channel records an event. That event can clear the channel's counter, and the channel can re-arm or stay disarmed afterwards.

Software reaches the bank through a simple register port, with writes and reads done in one cycle. Reading the counter of one of the two paired channels (9 and 11) can also capture the count of its partner into a snapshot register. Match events on channels whose enable input is high set status bits, and one interrupt line stays high while any status bit is set. The neighbouring register block clears status bits by pulsing `statusClr`.

Top module: `match_channel_bank`

## Requirements
- R1: After reset, every counter, match value, control word and the snapshot read as zero, status is zero and `irq` is low.
- R2: Control bits [2:0] pick the tick source. Codes 1..5 select `tickIn[0]`..`tickIn[4]` (32.768 kHz, 1 kHz, 1 Hz, 1 MHz, external). Codes 0, 6 and 7 hold the counter still. A running counter gains exactly one for each cycle its selected tick is high.
- R3: With control bit 3 set, a match event clears the channel's own counter to zero instead of letting it take the match value.
- R4: With control bit 6 set, the channel stays armed after a match. With bit 6 clear, it fires once and stays disarmed until its match value or control word is written again.
- R5: With control bit 7 clear, channels 5, 6 and 7 compare against channel 4's counter, channel 9 against channel 8's, and channel 11 against channel 10's. The non-lead channel's own counter then does not advance. Channels 4, 8 and 10 always use their own counter.
- R6: Control words of channels 4..7 keep bits [7:0] only. Those of channels 8..11 keep bits [9:0]. On channels 8..11, bit 8 holds the counter still.
- R7: When channel 9 or 11 has control bit 9 set, a read of its counter copies the current count of channel 8 or 10 into the snapshot. The snapshot is visible from the next cycle. Other reads leave the snapshot unchanged.
- R8: Byte offsets, word aligned, with channel k (0..7) at stride 4: counter at 0x40+4k, match at 0x80+4k, control at 0xC0+4k, snapshot at 0x20. Other offsets read as zero and write nothing.
- R9: A match event sets status bit k only when `matchEn[k]` is high. `irq` stays high while any status bit is set and falls only once all are cleared through `statusClr`.
- R10: A write to a counter wins over an increment in the same cycle.
- R11: A match event happens on the edge where the compared counter steps by a tick onto the match value. A counter write that lands on the match value fires nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 8 | Register byte offset |
| wrData | input | CNT_W (32) | Write data |
| rdData | output | CNT_W (32) | Read data, combinational from `addr` while `rdEn` is high |
| tickIn | input | 5 | Tick enables for source codes 1..5 |
| matchEn | input | 8 | Per-channel enable for setting status |
| statusClr | input | 8 | Per-channel status clear pulse |
| status | output | 8 | Per-channel match status |
| irq | output | 1 | Combined interrupt, OR of status |

## Verification
A wrong source decode or counter state shows up as a wrong count on the first counter read after a single tick pulse. The sweep therefore pulses each tick line alone against every source code on every channel. A broken arming flag or sharing selector shows at the status port on the edge of the step that should, or should not, fire. One-shot and periodic runs are checked across a second pass, because a stuck armed flag only differs there. The snapshot path and the control masks show on the next read.

// File: rtl/mcb_pkg.sv
package mcb_pkg;
  localparam int NUM_CH  = 8;
  localparam int IDX_W   = $clog2(NUM_CH);
  localparam int CTRL_W  = 10;
  localparam int NUM_SRC = 5;
  localparam int ADDR_W  = 8;

  // control bit positions
  localparam int CB_CLR  = 3;
  localparam int CB_PER  = 6;
  localparam int CB_OWN  = 7;
  localparam int CB_HALT = 8;
  localparam int CB_SNAP = 9;

  typedef enum logic [2:0] {RD_NONE, RD_MATCH, RD_COUNT, RD_CTRL, RD_SNAP} rdKind_e;

  typedef struct packed {
    logic [NUM_CH-1:0] wrMatch;
    logic [NUM_CH-1:0] wrCount;
    logic [NUM_CH-1:0] wrCtrl;
    logic [NUM_CH-1:0] rdCount;
    rdKind_e           rdKind;
    logic [IDX_W-1:0]  rdIdx;
  } strobe_t;

  // lead channel whose counter a channel shares when not using its own
  function automatic int leaderOf(int k);
    case (k)
      1, 2, 3: return 0;
      5:       return 4;
      7:       return 6;
      default: return k;
    endcase
  endfunction

  function automatic logic [CTRL_W-1:0] ctrlMask(int k);
    return (k >= 4) ? CTRL_W'(10'h3FF) : CTRL_W'(10'h0FF);
  endfunction

  function automatic logic canSnap(int k);
    return (k == 5) || (k == 7);
  endfunction
endpackage

// File: rtl/mcb_ctrl.sv
module mcb_ctrl
  import mcb_pkg::*;
(
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output strobe_t           strb
);
  logic [IDX_W-1:0] idx;
  logic             aligned;

  assign idx     = addr[4:2];
  assign aligned = (addr[1:0] == 2'b00);

  always_comb begin
    strb        = '0;
    strb.rdKind = RD_NONE;
    strb.rdIdx  = idx;
    if (aligned) begin
      case (addr[7:5])
        3'b010: begin
          if (wrEn) strb.wrCount[idx] = 1'b1;
          if (rdEn) begin
            strb.rdKind       = RD_COUNT;
            strb.rdCount[idx] = 1'b1;
          end
        end
        3'b100: begin
          if (wrEn) strb.wrMatch[idx] = 1'b1;
          if (rdEn) strb.rdKind = RD_MATCH;
        end
        3'b110: begin
          if (wrEn) strb.wrCtrl[idx] = 1'b1;
          if (rdEn) strb.rdKind = RD_CTRL;
        end
        3'b001: begin
          if (rdEn && idx == '0) strb.rdKind = RD_SNAP;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mcb_datapath.sv
module mcb_datapath
  import mcb_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [CNT_W-1:0]  wrData,
  input  logic [NUM_SRC-1:0] tickIn,
  input  logic [NUM_CH-1:0] matchEn,
  input  logic [NUM_CH-1:0] statusClr,
  output logic [CNT_W-1:0]  rdData,
  output logic [NUM_CH-1:0] status,
  output logic              irq
);
  logic [NUM_CH-1:0][CNT_W-1:0]  cntQ;
  logic [NUM_CH-1:0][CNT_W-1:0]  matchQ;
  logic [NUM_CH-1:0][CTRL_W-1:0] ctrlQ;
  logic [NUM_CH-1:0]             armedQ;
  logic [NUM_CH-1:0]             statusQ;
  logic [CNT_W-1:0]              snapQ;

  logic [NUM_CH-1:0] run;
  logic [NUM_CH-1:0] hit;
  logic              snapTake;
  logic [CNT_W-1:0]  snapVal;

  for (genvar j = 0; j < NUM_CH; j++) begin : g_ch
    localparam int LEAD = leaderOf(j);
    logic             srcTick;
    logic             useOwn;
    logic [CNT_W-1:0] cmpCnt;
    logic             cmpRun;
    logic             cmpWr;

    always_comb begin
      case (ctrlQ[j][2:0])
        3'd1:    srcTick = tickIn[0];
        3'd2:    srcTick = tickIn[1];
        3'd3:    srcTick = tickIn[2];
        3'd4:    srcTick = tickIn[3];
        3'd5:    srcTick = tickIn[4];
        default: srcTick = 1'b0;
      endcase
    end

    assign useOwn = (LEAD == j) || ctrlQ[j][CB_OWN];
    assign run[j] = srcTick && useOwn && !ctrlQ[j][CB_HALT];
    assign cmpCnt = useOwn ? cntQ[j] : cntQ[LEAD];
    assign cmpRun = useOwn ? run[j] : run[LEAD];
    assign cmpWr  = useOwn ? strb.wrCount[j] : strb.wrCount[LEAD];
    assign hit[j] = armedQ[j] && cmpRun && !cmpWr &&
                    ((cmpCnt + CNT_W'(1)) == matchQ[j]);
  end

  always_comb begin
    snapTake = 1'b0;
    snapVal  = '0;
    for (int k = 1; k < NUM_CH; k++) begin
      if (canSnap(k) && strb.rdCount[k] && ctrlQ[k][CB_SNAP]) begin
        snapTake = 1'b1;
        snapVal  = cntQ[k-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ    <= '0;
      matchQ  <= '0;
      ctrlQ   <= '0;
      armedQ  <= '1;
      statusQ <= '0;
      snapQ   <= '0;
    end else begin
      for (int k = 0; k < NUM_CH; k++) begin
        if (strb.wrCount[k])                cntQ[k] <= wrData;
        else if (hit[k] && ctrlQ[k][CB_CLR]) cntQ[k] <= '0;
        else if (run[k])                    cntQ[k] <= cntQ[k] + CNT_W'(1);

        if (strb.wrMatch[k]) matchQ[k] <= wrData;
        if (strb.wrCtrl[k])  ctrlQ[k]  <= wrData[CTRL_W-1:0] & ctrlMask(k);

        if (strb.wrMatch[k] || strb.wrCtrl[k]) armedQ[k] <= 1'b1;
        else if (hit[k] && !ctrlQ[k][CB_PER])  armedQ[k] <= 1'b0;
      end
      statusQ <= (statusQ & ~statusClr) | (hit & matchEn);
      if (snapTake) snapQ <= snapVal;
    end
  end

  always_comb begin
    case (strb.rdKind)
      RD_MATCH: rdData = matchQ[strb.rdIdx];
      RD_COUNT: rdData = cntQ[strb.rdIdx];
      RD_CTRL:  rdData = CNT_W'(ctrlQ[strb.rdIdx]);
      RD_SNAP:  rdData = snapQ;
      default:  rdData = '0;
    endcase
  end

  assign status = statusQ;
  assign irq    = |statusQ;
endmodule

// File: rtl/match_channel_bank.sv
module match_channel_bank
  import mcb_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic               rdEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [CNT_W-1:0]   wrData,
  output logic [CNT_W-1:0]   rdData,
  input  logic [NUM_SRC-1:0] tickIn,
  input  logic [NUM_CH-1:0]  matchEn,
  input  logic [NUM_CH-1:0]  statusClr,
  output logic [NUM_CH-1:0]  status,
  output logic               irq
);
  strobe_t strb;

  mcb_ctrl i_ctrl (
    .wrEn (wrEn),
    .rdEn (rdEn),
    .addr (addr),
    .strb (strb)
  );

  mcb_datapath #(.CNT_W(CNT_W)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrData    (wrData),
    .tickIn    (tickIn),
    .matchEn   (matchEn),
    .statusClr (statusClr),
    .rdData    (rdData),
    .status    (status),
    .irq       (irq)
  );
endmodule

// File: rtl/mcb_checker.sv
module mcb_checker
  import mcb_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              rdEn,
  input logic [ADDR_W-1:0] addr,
  input logic [CNT_W-1:0]  rdData,
  input logic [NUM_CH-1:0] matchEn,
  input logic [NUM_CH-1:0] statusClr,
  input logic [NUM_CH-1:0] status,
  input logic              irq,
  input strobe_t           strb
);
  // R8: at most one register is written per cycle
  assert_write_onehot_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrMatch, strb.wrCount, strb.wrCtrl}));

  // R8: no register write strobe without a bus write
  assert_write_needs_bus_R8: assert property (@(posedge clk) disable iff (!rstN)
    (|{strb.wrMatch, strb.wrCount, strb.wrCtrl}) |-> wrEn);

  // R6: narrow control words read back with upper bits clear
  assert_narrow_ctrl_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr[7:5] == 3'b110 && !addr[4] && addr[1:0] == 2'b00)
      |-> (rdData[CNT_W-1:8] == '0));

  // R6: wide control words read back with bits above 9 clear
  assert_wide_ctrl_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr[7:5] == 3'b110 && addr[4] && addr[1:0] == 2'b00)
      |-> (rdData[CNT_W-1:10] == '0));

  // R9: a status bit only rises for an enabled channel
  assert_status_needs_enable_R9: assert property (@(posedge clk) disable iff (!rstN)
    ((status & ~$past(status) & ~$past(matchEn)) == '0));

  // R9: interrupt holds while nothing is cleared
  assert_irq_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !(|statusClr)) |=> irq);

  // R9: interrupt only falls after a clear pulse
  assert_irq_fall_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irq) |-> $past(|statusClr));
endmodule

bind match_channel_bank mcb_checker #(.CNT_W(CNT_W)) i_mcb_checker (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .rdEn      (rdEn),
  .addr      (addr),
  .rdData    (rdData),
  .matchEn   (matchEn),
  .statusClr (statusClr),
  .status    (status),
  .irq       (irq),
  .strb      (strb)
);

// File: tb/test_match_channel_bank.sv
module test_match_channel_bank;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [4:0]  tickIn = '0;
  logic [7:0]  matchEn = '0;
  logic [7:0]  statusClr = '0;
  logic [7:0]  status;
  logic        irq;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  match_channel_bank i_match_channel_bank (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .tickIn(tickIn), .matchEn(matchEn),
    .statusClr(statusClr), .status(status), .irq(irq)
  );

  function automatic logic [7:0] cntA(int k);   return 8'h40 + 8'(4*k); endfunction
  function automatic logic [7:0] matchA(int k); return 8'h80 + 8'(4*k); endfunction
  function automatic logic [7:0] ctrlA(int k);  return 8'hC0 + 8'(4*k); endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk); rdEn = 1'b1; addr = a;
    #1 v = rdData;
    @(negedge clk); rdEn = 1'b0;
  endtask

  task automatic pulse(input logic [4:0] m);
    @(negedge clk); tickIn = m;
    @(negedge clk); tickIn = '0;
  endtask

  task automatic clr(input logic [7:0] m);
    @(negedge clk); statusClr = m;
    @(negedge clk); statusClr = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    for (int k = 0; k < 8; k++) begin
      rd(cntA(k), v);   check("R1 counter", v, 0);
      rd(matchA(k), v); check("R1 match", v, 0);
      rd(ctrlA(k), v);  check("R1 control", v, 0);
    end
    rd(8'h20, v); check("R1 snapshot", v, 0);
    check("R1 status", 32'(status), 0);
    check("R1 irq", 32'(irq), 0);

    // R2: each tick line alone against every source code
    for (int k = 0; k < 8; k++) begin
      for (int code = 0; code < 8; code++) begin
        wr(ctrlA(k), 32'h80 | code);
        wr(cntA(k), 0);
        for (int s = 0; s < 5; s++) pulse(5'(1 << s));
        rd(cntA(k), v);
        check($sformatf("R2 ch%0d code%0d", k, code), v,
              (code >= 1 && code <= 5) ? 1 : 0);
      end
      // R6: halt bit on wide channels
      if (k >= 4) begin
        wr(ctrlA(k), 32'h181);
        wr(cntA(k), 0);
        pulse(5'h01);
        rd(cntA(k), v);
        check("R6 halt bit", v, 0);
      end
    end

    // R6 / R8: control masks and register map readback
    for (int k = 0; k < 8; k++) begin
      wr(ctrlA(k), 32'hFFFF_FFFF);
      rd(ctrlA(k), v);
      check("R6 control mask", v, (k < 4) ? 32'hFF : 32'h3FF);
      wr(ctrlA(k), 0);
      wr(matchA(k), 32'hA500_0000 + k);
      wr(cntA(k), 32'h0C00_0000 + k);
    end
    for (int k = 0; k < 8; k++) begin
      rd(matchA(k), v); check("R8 match map", v, 32'hA500_0000 + k);
      rd(cntA(k), v);   check("R8 counter map", v, 32'h0C00_0000 + k);
    end
    wr(8'h30, 32'h1234_5678);
    rd(8'h30, v); check("R8 unmapped read", v, 0);
    rd(8'h20, v); check("R8 snapshot untouched", v, 0);

    matchEn = 8'hFF;
    // R9 / R11: plain match on channel 4 (k=0)
    wr(cntA(0), 0); wr(matchA(0), 3); wr(ctrlA(0), 1);
    pulse(5'h01); pulse(5'h01);
    check("R11 no early match", 32'(status), 0);
    pulse(5'h01);
    check("R11 match on step", 32'(status), 32'h01);
    check("R9 irq on match", 32'(irq), 1);
    rd(cntA(0), v); check("R3 no clear when bit3 off", v, 3);
    clr(8'h01);
    check("R9 cleared status", 32'(status), 0);
    check("R9 irq falls", 32'(irq), 0);

    // R3 / R4: periodic with clear
    wr(cntA(0), 0); wr(ctrlA(0), 32'h49);
    repeat (3) pulse(5'h01);
    check("R3 status first", 32'(status), 32'h01);
    rd(cntA(0), v); check("R3 counter cleared", v, 0);
    clr(8'h01);
    repeat (3) pulse(5'h01);
    check("R4 periodic refires", 32'(status), 32'h01);
    clr(8'h01);

    // R4: one-shot
    wr(cntA(0), 0); wr(ctrlA(0), 32'h09);
    repeat (3) pulse(5'h01);
    check("R4 one-shot first", 32'(status), 32'h01);
    clr(8'h01);
    repeat (3) pulse(5'h01);
    check("R4 one-shot silent", 32'(status), 0);
    rd(cntA(0), v); check("R4 counter runs on", v, 3);

    // R9: disabled channel does not set status
    matchEn = 8'hFE;
    wr(cntA(0), 0); wr(matchA(0), 3); wr(ctrlA(0), 1);
    repeat (3) pulse(5'h01);
    check("R9 disabled no status", 32'(status), 0);
    check("R9 disabled no irq", 32'(irq), 0);
    matchEn = 8'hFF;

    // R5: channel 5 (k=1) shares channel 4's counter
    wr(ctrlA(0), 0); wr(cntA(0), 0); wr(matchA(0), 100);
    wr(cntA(1), 32'h10); wr(matchA(1), 2); wr(ctrlA(1), 1);
    wr(ctrlA(0), 1);
    pulse(5'h01); pulse(5'h01);
    check("R5 shared match", 32'(status), 32'h02);
    rd(cntA(1), v); check("R5 follower counter stopped", v, 32'h10);
    wr(ctrlA(0), 0);
    clr(8'h02);
    // R5: own counter with bit7
    wr(cntA(1), 0); wr(ctrlA(1), 32'h81);
    pulse(5'h01); pulse(5'h01);
    check("R5 own counter match", 32'(status), 32'h02);
    wr(ctrlA(1), 0);
    clr(8'h02);
    // R5: channels 9 and 11 follow 8 and 10
    wr(matchA(4), 50); wr(matchA(6), 50);
    wr(cntA(4), 0); wr(cntA(6), 0);
    wr(matchA(5), 1); wr(matchA(7), 1);
    wr(ctrlA(5), 0); wr(ctrlA(7), 0);
    wr(ctrlA(4), 1); wr(ctrlA(6), 1);
    pulse(5'h01);
    check("R5 pairs 9/8 and 11/10", 32'(status), 32'hA0);
    wr(ctrlA(4), 0); wr(ctrlA(6), 0);
    // R9: irq holds until the last bit clears
    clr(8'h20);
    check("R9 irq holds", 32'(irq), 1);
    clr(8'h80);
    check("R9 irq drops", 32'(irq), 0);

    // R10 / R11: write wins over tick, write onto match is silent
    wr(ctrlA(0), 1); wr(matchA(0), 32'h77);
    @(negedge clk); wrEn = 1'b1; addr = cntA(0); wrData = 32'h77; tickIn = 5'h01;
    @(negedge clk); wrEn = 1'b0; tickIn = '0;
    rd(cntA(0), v); check("R10 write wins", v, 32'h77);
    check("R11 write onto match silent", 32'(status), 0);
    wr(matchA(0), 32'h79);
    pulse(5'h01);
    check("R11 no match one short", 32'(status), 0);
    pulse(5'h01);
    check("R11 match after second step", 32'(status), 32'h01);
    wr(ctrlA(0), 0);
    clr(8'h01);

    // R7: snapshot capture
    wr(cntA(4), 32'h1234); wr(ctrlA(5), 32'h200);
    rd(cntA(5), v);
    rd(8'h20, v); check("R7 snapshot 9 from 8", v, 32'h1234);
    wr(ctrlA(5), 0); wr(cntA(4), 32'h99);
    rd(cntA(5), v);
    rd(8'h20, v); check("R7 no capture without bit9", v, 32'h1234);
    wr(cntA(6), 32'h5555); wr(ctrlA(7), 32'h200);
    rd(cntA(7), v);
    rd(8'h20, v); check("R7 snapshot 11 from 10", v, 32'h5555);
    wr(ctrlA(1), 32'h200); wr(cntA(0), 32'h42);
    rd(cntA(1), v);
    rd(8'h20, v); check("R7 narrow channel no capture", v, 32'h5555);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule